// File: doc/BRIEF.md
# Coded Frame Header Encoder

This block turns the fields of a physical-layer frame header into the coded bit stream that leads each frame. A `start` pulse captures the header fields from ports: modulation-and-coding index, pilot-word flag, payload scrambler seed identifier and payload length in octets. The block then asks for a fixed number of MAC header bytes on a valid/ready byte stream. It runs a 16-bit header check sequence over the PHY and MAC header bits, appends it, and pads with zero stuff bits to a whole number of 4-bit groups. It whitens everything with a 15-bit scrambler and protects each 4-bit group with an (8,4) extended Hamming code.

The coded bits leave one per clock on `cw_bit`, qualified by `cw_valid`. A later stage does spreading, mapping and sub-block assembly. `busy` covers the whole run, from the cycle after an accepted `start` up to and including the last coded bit.

Top module: `hdr_fec_encoder`

## Requirements
- R1: After reset, `busy`, `cw_valid` and `mac_ready` are 0.
- R2: The PHY header is 33 bits and is sent bit 0 first. `mcs_idx` is at bits 2..0, `pilot_on` at bit 3 and `seed_field` at bits 7..4. Bits 12..8 are zero. `psdu_len` is at bits 32..13.
- R3: After the PHY header, exactly `MAC_BYTES` bytes are taken, each on a cycle where `mac_valid` and `mac_ready` are both 1. They are sent in arrival order, each least significant bit first. `mac_ready` stays high until a byte is taken.
- R4: The check sequence runs over the PHY and MAC header bits in send order. The register is preset to 0xFFFF. For each bit, fb = reg[15] ^ bit, then reg = (reg << 1) ^ (fb ? 0xA12B : 0), which is generator 0x1A12B. The complement of the final register follows the MAC header, bit 15 first.
- R5: Zero stuff bits follow the check sequence until the length is a multiple of 4. With the default eight MAC bytes, 3 stuff bits are added, for 116 bits in total.
- R6: Every bit is XORed with a keystream, from PHY bit 0 through the last stuff bit. The state starts at {`hdr_scr_seed`, eleven ones}. For each bit, k = s[14] ^ s[13], and then s = {s[13:0], k}.
- R7: Each run of four scrambled bits i0..i3 (i0 first) is sent as i0, i1, i2, i3, p0, p1, p2, p3. Here p0 = i1^i2^i3, p1 = i0^i2^i3, p2 = i0^i1^i3 and p3 = i0^i1^i2.
- R8: `busy` rises the cycle after an accepted `start`. `cw_valid` is only high while `busy`. A frame yields exactly twice the padded header length in coded bits, and then `busy` falls.
- R9: A `start` pulse while `busy` is ignored and does not change the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame header (taken when not busy) |
| mcs_idx | input | 3 | Modulation and coding index |
| pilot_on | input | 1 | Pilot-word flag |
| seed_field | input | 4 | Payload scrambler seed identifier (header field) |
| psdu_len | input | 20 | Payload length in octets |
| hdr_scr_seed | input | 4 | Seed for the header scrambler |
| mac_valid | input | 1 | MAC header byte available |
| mac_byte | input | 8 | MAC header byte |
| mac_ready | output | 1 | Block takes a MAC byte this cycle if valid |
| busy | output | 1 | Frame in progress |
| cw_valid | output | 1 | Coded bit valid |
| cw_bit | output | 1 | Coded bit |

## Verification
The hardest case to reach from the ports is a source that stalls in the middle of a 4-bit group. While a MAC byte is missing, the coder must finish emitting the current codeword and then sit idle without losing or reordering bits. The bench reaches this by holding `mac_valid` low for several cycles between bytes of one frame. A reference model then compares every coded bit against a queue built from the requirement equations. A second `start`, carrying different fields, is injected while such a frame is running.

// File: rtl/hfe_pkg.sv
package hfe_pkg;
  localparam int CRC_W      = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'hA12B;
  localparam int SCR_W      = 15;
  localparam int SEED_W     = 4;
  localparam int LEN_POS    = 13;
  localparam int GRP_W      = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PHY,
    PH_MAC,
    PH_HCS,
    PH_STUFF
  } phase_t;

  // parity nibble {p3,p2,p1,p0} of an (8,4) extended Hamming word
  function automatic logic [3:0] ham_parity(input logic [3:0] d);
    logic [3:0] p;
    p[0] = d[1] ^ d[2] ^ d[3];
    p[1] = d[0] ^ d[2] ^ d[3];
    p[2] = d[0] ^ d[1] ^ d[3];
    p[3] = d[0] ^ d[1] ^ d[2];
    return p;
  endfunction
endpackage

// File: rtl/hfe_crc.sv
module hfe_crc #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'hA12B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc_q
);
  logic fb;
  assign fb = crc_q[W-1] ^ din;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc_q <= '1;
    end else if (en) begin
      crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end
endmodule

// File: rtl/hfe_scrambler.sv
module hfe_scrambler #(
  parameter int SW    = 15,
  parameter int SEEDW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic [SEEDW-1:0] seed,
  input  logic             step,
  output logic             ks
);
  logic [SW-1:0] st;
  assign ks = st[SW-1] ^ st[SW-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '1;
    end else if (init) begin
      st <= {seed, {(SW-SEEDW){1'b1}}};
    end else if (step) begin
      st <= {st[SW-2:0], ks};
    end
  end
endmodule

// File: rtl/hfe_hdr_source.sv
module hfe_hdr_source
  import hfe_pkg::*;
#(
  parameter int MAC_BYTES  = 8,
  parameter int STUFF_BITS = 3,
  parameter int LEN_W      = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [2:0]       mcs_idx,
  input  logic             pilot_on,
  input  logic [3:0]       seed_field,
  input  logic [LEN_W-1:0] psdu_len,
  input  logic             mac_valid,
  input  logic [7:0]       mac_byte,
  output logic             mac_ready,
  input  logic [CRC_W-1:0] hcs_reg,
  input  logic             take,
  output logic             bit_valid,
  output logic             bit_data,
  output logic             crc_en,
  output logic             active
);
  localparam int PHY_BITS = LEN_POS + LEN_W;
  localparam int CNT_W    = $clog2(PHY_BITS + 1);
  localparam int BCNT_W   = $clog2(MAC_BYTES + 1);

  phase_t                phase;
  logic [PHY_BITS-1:0]   sh;
  logic [CNT_W-1:0]      cnt;
  logic [BCNT_W-1:0]     bcnt;
  logic                  have;
  logic [CRC_W-1:0]      hcs_out;
  logic [3:0]            hcs_idx;

  assign hcs_out   = ~hcs_reg;
  assign hcs_idx   = 4'(CRC_W - 1) - cnt[3:0];
  assign active    = (phase != PH_IDLE);
  assign mac_ready = (phase == PH_MAC) && !have;
  assign crc_en    = take && ((phase == PH_PHY) || (phase == PH_MAC));

  always_comb begin
    bit_valid = 1'b0;
    bit_data  = 1'b0;
    unique case (phase)
      PH_PHY:   begin bit_valid = 1'b1; bit_data = sh[0]; end
      PH_MAC:   begin bit_valid = have; bit_data = sh[0]; end
      PH_HCS:   begin bit_valid = 1'b1; bit_data = hcs_out[hcs_idx]; end
      PH_STUFF: begin bit_valid = 1'b1; bit_data = 1'b0; end
      default:  begin bit_valid = 1'b0; bit_data = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      sh    <= '0;
      cnt   <= '0;
      bcnt  <= '0;
      have  <= 1'b0;
    end else if (go) begin
      phase <= PH_PHY;
      sh    <= {psdu_len, 5'b0, seed_field, pilot_on, mcs_idx};
      cnt   <= '0;
      bcnt  <= '0;
      have  <= 1'b0;
    end else begin
      unique case (phase)
        PH_PHY: if (take) begin
          sh  <= sh >> 1;
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(PHY_BITS - 1)) begin
            phase <= PH_MAC;
            cnt   <= '0;
          end
        end
        PH_MAC: begin
          if (!have && mac_valid) begin
            sh[7:0] <= mac_byte;
            have    <= 1'b1;
            cnt     <= '0;
          end else if (take) begin
            sh  <= sh >> 1;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(7)) begin
              have <= 1'b0;
              bcnt <= bcnt + 1'b1;
              cnt  <= '0;
              if (bcnt == BCNT_W'(MAC_BYTES - 1)) phase <= PH_HCS;
            end
          end
        end
        PH_HCS: if (take) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(CRC_W - 1)) begin
            cnt   <= '0;
            phase <= (STUFF_BITS == 0) ? PH_IDLE : PH_STUFF;
          end
        end
        PH_STUFF: if (take) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(STUFF_BITS - 1)) phase <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hfe_ham_ser.sv
module hfe_ham_ser
  import hfe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic cw_valid,
  output logic cw_bit,
  output logic busy
);
  logic [GRP_W-1:0]   nib;
  logic [2:0]         ncnt;
  logic [2*GRP_W-1:0] osh;
  logic [3:0]         ocnt;
  logic               load;

  assign in_ready = (ncnt != 3'(GRP_W));
  assign load     = (ncnt == 3'(GRP_W)) && (ocnt <= 4'd1);
  assign cw_valid = (ocnt != 4'd0);
  assign cw_bit   = osh[0];
  assign busy     = (ncnt != 3'd0) || (ocnt != 4'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      nib  <= '0;
      ncnt <= '0;
      osh  <= '0;
      ocnt <= '0;
    end else if (load) begin
      osh  <= {ham_parity(nib), nib};
      ocnt <= 4'(2 * GRP_W);
      ncnt <= '0;
    end else begin
      if (ocnt != 4'd0) begin
        osh  <= {1'b0, osh[2*GRP_W-1:1]};
        ocnt <= ocnt - 1'b1;
      end
      if (in_valid && in_ready) begin
        nib[ncnt[1:0]] <= in_bit;
        ncnt           <= ncnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdr_fec_encoder.sv
module hdr_fec_encoder
  import hfe_pkg::*;
#(
  parameter int MAC_BYTES = 8,
  parameter int LEN_W     = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       mcs_idx,
  input  logic             pilot_on,
  input  logic [3:0]       seed_field,
  input  logic [LEN_W-1:0] psdu_len,
  input  logic [3:0]       hdr_scr_seed,
  input  logic             mac_valid,
  input  logic [7:0]       mac_byte,
  output logic             mac_ready,
  output logic             busy,
  output logic             cw_valid,
  output logic             cw_bit
);
  localparam int PRE_BITS   = LEN_POS + LEN_W + 8 * MAC_BYTES + CRC_W;
  localparam int STUFF_BITS = (GRP_W - (PRE_BITS % GRP_W)) % GRP_W;

  logic             go;
  logic             src_active, ham_busy;
  logic             bit_valid, bit_data, crc_en, take, in_ready, ks;
  logic [CRC_W-1:0] crc_q;

  assign busy = src_active || ham_busy;
  assign go   = start && !busy;
  assign take = bit_valid && in_ready;

  hfe_hdr_source #(
    .MAC_BYTES (MAC_BYTES),
    .STUFF_BITS(STUFF_BITS),
    .LEN_W     (LEN_W)
  ) u_src (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .mcs_idx   (mcs_idx),
    .pilot_on  (pilot_on),
    .seed_field(seed_field),
    .psdu_len  (psdu_len),
    .mac_valid (mac_valid),
    .mac_byte  (mac_byte),
    .mac_ready (mac_ready),
    .hcs_reg   (crc_q),
    .take      (take),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .crc_en    (crc_en),
    .active    (src_active)
  );

  hfe_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (go),
    .en   (crc_en),
    .din  (bit_data),
    .crc_q(crc_q)
  );

  hfe_scrambler #(.SW(SCR_W), .SEEDW(SEED_W)) u_scr (
    .clk (clk),
    .rst (rst),
    .init(go),
    .seed(hdr_scr_seed),
    .step(take),
    .ks  (ks)
  );

  hfe_ham_ser u_ham (
    .clk     (clk),
    .rst     (rst),
    .in_valid(bit_valid),
    .in_bit  (bit_data ^ ks),
    .in_ready(in_ready),
    .cw_valid(cw_valid),
    .cw_bit  (cw_bit),
    .busy    (ham_busy)
  );
endmodule

// File: rtl/hfe_chk.sv
module hfe_chk #(
  parameter int MAC_BYTES = 8,
  parameter int LEN_W     = 20
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic cw_valid,
  input logic mac_ready,
  input logic mac_valid
);
  localparam int PRE   = 13 + LEN_W + 8 * MAC_BYTES + 16;
  localparam int TOTAL = PRE + (4 - PRE % 4) % 4;

  logic [15:0] vcnt;
  logic [15:0] mcnt;

  always_ff @(posedge clk) begin
    if (rst || (start && !busy)) begin
      vcnt <= '0;
      mcnt <= '0;
    end else begin
      if (cw_valid) vcnt <= vcnt + 1'b1;
      if (mac_valid && mac_ready) mcnt <= mcnt + 1'b1;
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (rst) !busy |-> (!cw_valid && !mac_ready));
  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  p_bit_total_r8: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (vcnt == 16'(2 * TOTAL)));
  p_byte_total_r3: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (mcnt == 16'(MAC_BYTES)));
  p_ready_hold_r3: assert property (@(posedge clk) disable iff (rst) (mac_ready && !mac_valid) |=> mac_ready);
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst) (start && busy && cw_valid) |=> busy);
endmodule

bind hdr_fec_encoder hfe_chk #(.MAC_BYTES(MAC_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .cw_valid (cw_valid),
  .mac_ready(mac_ready),
  .mac_valid(mac_valid)
);

// File: tb/hdr_fec_encoder_tb.sv
module hdr_fec_encoder_tb;
  localparam int MACB = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mcs_idx = '0;
  logic        pilot_on = 1'b0;
  logic [3:0]  seed_field = '0;
  logic [19:0] psdu_len = '0;
  logic [3:0]  hdr_scr_seed = '0;
  logic        mac_valid = 1'b0;
  logic [7:0]  mac_byte = '0;
  logic        mac_ready, busy, cw_valid, cw_bit;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit    exp_q[$];
  string tag_q[$];
  logic [7:0] mac_buf [MACB];

  always #4 clk = ~clk;

  hdr_fec_encoder u_dut (
    .clk(clk), .rst(rst), .start(start), .mcs_idx(mcs_idx), .pilot_on(pilot_on),
    .seed_field(seed_field), .psdu_len(psdu_len), .hdr_scr_seed(hdr_scr_seed),
    .mac_valid(mac_valid), .mac_byte(mac_byte), .mac_ready(mac_ready),
    .busy(busy), .cw_valid(cw_valid), .cw_bit(cw_bit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // reference model: push the expected coded bits of one frame
  task automatic build(input logic [2:0] m, input logic p, input logic [3:0] sd,
                       input logic [19:0] ln, input logic [3:0] ss);
    bit src[$];
    string cat[$];
    logic [32:0] phy;
    logic [15:0] c;
    logic [14:0] s;
    phy = {ln, 5'b0, sd, p, m};
    for (int i = 0; i < 33; i++) begin src.push_back(phy[i]); cat.push_back("R2"); end
    for (int k = 0; k < MACB; k++)
      for (int j = 0; j < 8; j++) begin src.push_back(mac_buf[k][j]); cat.push_back("R3"); end
    c = 16'hFFFF;
    foreach (src[i]) begin
      bit fb;
      fb = c[15] ^ src[i];
      c  = {c[14:0], 1'b0} ^ (fb ? 16'hA12B : 16'h0000);
    end
    c = ~c;
    for (int j = 15; j >= 0; j--) begin src.push_back(c[j]); cat.push_back("R4"); end
    while (src.size() % 4 != 0) begin src.push_back(1'b0); cat.push_back("R5"); end
    s = {ss, 11'h7FF};
    foreach (src[i]) begin
      bit k;
      k = s[14] ^ s[13];
      src[i] = src[i] ^ k;
      s = {s[13:0], k};
    end
    for (int g = 0; g < src.size() / 4; g++) begin
      bit d0, d1, d2, d3;
      d0 = src[4*g]; d1 = src[4*g+1]; d2 = src[4*g+2]; d3 = src[4*g+3];
      for (int j = 0; j < 4; j++) begin
        exp_q.push_back(src[4*g+j]);
        tag_q.push_back({cat[4*g+j], "+R6"});
      end
      exp_q.push_back(d1 ^ d2 ^ d3); tag_q.push_back("R7 p0");
      exp_q.push_back(d0 ^ d2 ^ d3); tag_q.push_back("R7 p1");
      exp_q.push_back(d0 ^ d1 ^ d3); tag_q.push_back("R7 p2");
      exp_q.push_back(d0 ^ d1 ^ d2); tag_q.push_back("R7 p3");
    end
  endtask

  // monitor: compare every coded bit against the scoreboard
  always @(negedge clk) begin
    if (!rst && cw_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: actual=extra coded bit %b expected=none", cw_bit);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, cw_bit, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic feed_mac(input int gap);
    for (int k = 0; k < MACB; k++) begin
      mac_byte  = mac_buf[k];
      mac_valid = 1'b1;
      #1;
      while (!mac_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      mac_valid = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic [2:0] m, input logic p, input logic [3:0] sd,
                           input logic [19:0] ln, input logic [3:0] ss, input int gap,
                           input bit poke);
    build(m, p, sd, ln, ss);
    @(negedge clk);
    mcs_idx = m; pilot_on = p; seed_field = sd; psdu_len = ln; hdr_scr_seed = ss;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", busy, 1'b1);
    fork
      feed_mac(gap);
      if (poke) begin
        // R9: a second start with different fields while busy
        repeat (40) @(negedge clk);
        mcs_idx = ~m; psdu_len = ~ln; hdr_scr_seed = ~ss; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 still busy", busy, 1'b1);
      end
    join
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8: actual=%0d bits missing expected=0", exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", busy, 1'b0);
    check("R1 cw_valid", cw_valid, 1'b0);
    check("R1 mac_ready", mac_ready, 1'b0);

    for (int k = 0; k < MACB; k++) mac_buf[k] = 8'(8'h11 * (k + 1));
    run_frame(3'd2, 1'b1, 4'h9, 20'h04000, 4'h5, 0, 1'b0);

    for (int k = 0; k < MACB; k++) mac_buf[k] = 8'hFF;
    run_frame(3'd7, 1'b1, 4'hF, 20'hFFFFF, 4'hF, 11, 1'b0);

    for (int k = 0; k < MACB; k++) mac_buf[k] = 8'h00;
    run_frame(3'd0, 1'b0, 4'h0, 20'h00000, 4'h0, 1, 1'b0);

    for (int k = 0; k < MACB; k++) mac_buf[k] = 8'(8'hA5 ^ (k * 37));
    run_frame(3'd5, 1'b0, 4'h3, 20'h3039A, 4'hC, 3, 1'b1);

    check("R1 idle at end", busy, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule